// File: doc/BRIEF.md
# Palette Entry Color Converter

This block turns raw 32-bit palette words into a uniform internal colour: an 8-bit red, green and blue value and one transparency flag. Software points it at a palette buffer, selects one of four packed layouts and an optional grayscale override, and pulses `start`. The block then pulls exactly as many words as the frame's indexed colour depth needs and streams one converted entry out for each. The stream stops only when either side stalls. At the end it gives a single-cycle completion pulse.

It also keeps the layout code used by the last finished conversion. A status output shows when the layout now selected no longer matches that code, so the caller knows the palette must be converted again.

Top module: `palette_color_conv`

## Requirements
- R1: At `start`, the depth code sets the entry count: code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. Exactly that many input words are accepted in a run.
- R2: Any other depth code converts nothing. `in_ready` stays low and `done` is high in the cycle after the `start` cycle.
- R3: Layout 0: red = word[15:11]<<3, green = word[10:5]<<2, blue = word[4:0]<<3. Transparency is 0. The low bits of each expanded field are zero.
- R4: Layout 1 extracts colour as layout 0 does. Transparency is word bit 24.
- R5: Layout 2: red = word[23:19]<<3, green = word[15:10]<<2, blue = word[7:3]<<3. Transparency is word bit 24.
- R6: Layout 3: red = word[23:16], green = word[15:8], blue = word[7:0]. Transparency is word bit 24.
- R7: With `mono` set, all three channels equal word[7:0] under every layout. Transparency still follows the layout.
- R8: `out_rgb` carries red in [23:16], green in [15:8] and blue in [7:0]. Entries leave in the order the words were accepted.
- R9: `fmt_stale` is high after reset. It is high whenever `pal_fmt` differs from the layout of the last completed conversion, and low otherwise.
- R10: When both sides are ready, one entry moves per clock. While `out_valid` is high and `out_ready` is low, `out_rgb` and `out_transp` hold their values.
- R11: `done` is a one-cycle pulse in the cycle after the final output handshake. A `start` during a run has no effect.
- R12: Layout, `mono` and depth are captured at `start`. Changing them during a run does not change the converted values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion run (sampled when idle) |
| depth_code | input | 4 | Indexed colour depth code |
| pal_fmt | input | 2 | Palette word layout |
| mono | input | 1 | Grayscale override |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Raw palette word |
| in_ready | output | 1 | Block accepts a word |
| out_valid | output | 1 | Converted entry valid |
| out_ready | input | 1 | Consumer accepts the entry |
| out_rgb | output | 24 | Converted colour |
| out_transp | output | 1 | Transparency flag |
| done | output | 1 | Run complete pulse |
| fmt_stale | output | 1 | Selected layout differs from last converted layout |

## Verification
The hardest case to reach is the last entry of a run while the output is stalled and a new word is still offered. Here the block must refuse the extra word, keep the held entry unchanged and delay `done` until the consumer takes it. The bench reaches this with long runs under heavy random back-pressure on both sides. It also changes the layout and `mono` inputs and pulses a stray `start` in the middle of a run, so that capture-at-start is tested under load.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef struct packed {
        logic [1:0] fmt;
        logic       mono;
    } pcc_cfg_t;

    typedef struct packed {
        logic        transp;
        logic [7:0]  red;
        logic [7:0]  green;
        logic [7:0]  blue;
    } pcc_color_t;

endpackage

// File: rtl/pcc_entry_decode.sv
module pcc_entry_decode
    import pcc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    input  pcc_cfg_t          cfg_i,
    output pcc_color_t        color_o
);
    localparam int TBIT = 24;

    always_comb begin
        color_o = '0;
        unique case (cfg_i.fmt)
            2'd0, 2'd1: begin
                color_o.red   = {word_i[15:11], 3'b000};
                color_o.green = {word_i[10:5],  2'b00};
                color_o.blue  = {word_i[4:0],   3'b000};
            end
            2'd2: begin
                color_o.red   = {word_i[23:19], 3'b000};
                color_o.green = {word_i[15:10], 2'b00};
                color_o.blue  = {word_i[7:3],   3'b000};
            end
            default: begin
                color_o.red   = word_i[23:16];
                color_o.green = word_i[15:8];
                color_o.blue  = word_i[7:0];
            end
        endcase
        color_o.transp = (cfg_i.fmt != 2'd0) ? word_i[TBIT] : 1'b0;
        if (cfg_i.mono) begin
            color_o.red   = word_i[7:0];
            color_o.green = word_i[7:0];
            color_o.blue  = word_i[7:0];
        end
    end
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
    import pcc_pkg::*;
#(
    parameter int DEPTH_W  = 4,
    parameter int MAX_CODE = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [1:0]         fmt_live_i,
    input  logic               mono_i,
    input  logic               take_i,
    input  logic               fire_i,
    output logic               room_o,
    output pcc_cfg_t           cfg_o,
    output logic               done_o,
    output logic               stale_o
);
    localparam int CNT_W = (1 << MAX_CODE) + 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        pcc_cfg_t         cfg;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] in_cnt;
        logic [CNT_W-1:0] out_cnt;
        logic [1:0]       used_fmt;
        logic             used_ok;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [CNT_W-1:0] entries_for(input logic [DEPTH_W-1:0] code);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int c = 1; c <= MAX_CODE; c++) begin
            if (code == DEPTH_W'(c)) n = CNT_W'(1) << (1 << c);
        end
        return n;
    endfunction

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.cfg     = '{fmt: fmt_live_i, mono: mono_i};
                s_d.total   = entries_for(depth_i);
                s_d.in_cnt  = '0;
                s_d.out_cnt = '0;
                if (entries_for(depth_i) == '0) s_d.done = 1'b1;
                else                            s_d.busy = 1'b1;
            end
        end else begin
            if (take_i) s_d.in_cnt = s_q.in_cnt + 1'b1;
            if (fire_i) begin
                s_d.out_cnt = s_q.out_cnt + 1'b1;
                if (s_q.out_cnt + 1'b1 == s_q.total) begin
                    s_d.busy     = 1'b0;
                    s_d.done     = 1'b1;
                    s_d.used_fmt = s_q.cfg.fmt;
                    s_d.used_ok  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign room_o  = s_q.busy && (s_q.in_cnt < s_q.total);
    assign cfg_o   = s_q.cfg;
    assign done_o  = s_q.done;
    assign stale_o = !s_q.used_ok || (fmt_live_i != s_q.used_fmt);

    assert_no_take_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> s_q.busy);
    assert_take_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (s_q.in_cnt < s_q.total));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> $stable(s_q.cfg));
endmodule

// File: rtl/palette_color_conv.sv
module palette_color_conv
    import pcc_pkg::*;
#(
    parameter int DEPTH_W  = 4,
    parameter int MAX_CODE = 3,
    parameter int WORD_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DEPTH_W-1:0] depth_code,
    input  logic [1:0]         pal_fmt,
    input  logic               mono,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [23:0]        out_rgb,
    output logic               out_transp,
    output logic               done,
    output logic               fmt_stale
);
    typedef struct packed {
        logic       valid;
        pcc_color_t color;
    } oreg_t;

    oreg_t      o_d, o_q;
    pcc_cfg_t   cfg;
    pcc_color_t conv;
    logic       room, take, fire;

    assign fire     = o_q.valid && out_ready;
    assign in_ready = room && (!o_q.valid || out_ready);
    assign take     = in_valid && in_ready;

    pcc_seq #(.DEPTH_W(DEPTH_W), .MAX_CODE(MAX_CODE)) i_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .depth_i(depth_code),
        .fmt_live_i(pal_fmt), .mono_i(mono), .take_i(take), .fire_i(fire),
        .room_o(room), .cfg_o(cfg), .done_o(done), .stale_o(fmt_stale)
    );

    pcc_entry_decode #(.WORD_W(WORD_W)) i_dec (
        .word_i(in_word), .cfg_i(cfg), .color_o(conv)
    );

    always_comb begin
        o_d = o_q;
        if (fire) o_d.valid = 1'b0;
        if (take) begin
            o_d.valid = 1'b1;
            o_d.color = conv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid  = o_q.valid;
    assign out_rgb    = {o_q.color.red, o_q.color.green, o_q.color.blue};
    assign out_transp = o_q.color.transp;

    assert_hold_when_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_transp)));
endmodule

// File: tb/test_palette_color_conv.sv
module test_palette_color_conv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  depth_code = '0;
    logic [1:0]  pal_fmt = '0;
    logic        mono = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready, out_valid, out_transp, done, fmt_stale;
    logic        out_ready = 1'b0;
    logic [23:0] out_rgb;

    int checks = 0, errors = 0, cycles = 0;
    int used_fmt = 0;
    bit used_ok = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    palette_color_conv i_palette_color_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .depth_code(depth_code),
        .pal_fmt(pal_fmt), .mono(mono), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_rgb(out_rgb), .out_transp(out_transp), .done(done), .fmt_stale(fmt_stale)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint ref_conv(input logic [31:0] w, input int f, input bit m);
        longint r, g, b, t;
        if (f <= 1) begin
            r = ((w >> 11) % 32) * 8; g = ((w >> 5) % 64) * 4; b = (w % 32) * 8;
        end else if (f == 2) begin
            r = ((w >> 19) % 32) * 8; g = ((w >> 10) % 64) * 4; b = ((w >> 3) % 32) * 8;
        end else begin
            r = (w >> 16) % 256; g = (w >> 8) % 256; b = w % 256;
        end
        if (m) begin r = w % 256; g = r; b = r; end
        t = (f == 0) ? 0 : ((w >> 24) % 2);
        return t * 64'h1000000 + r * 65536 + g * 256 + b;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(input int depth, input int f, input bit m, input bit scramble, input int stall);
        longint q[$];
        int total, accs, outs;
        bit exp_done, prev_stall;
        longint prev_out;
        string tag;
        total = (depth >= 1 && depth <= 3) ? (1 << (1 << depth)) : 0;
        tag = m ? "R7" : (f == 0 ? "R3" : f == 1 ? "R4" : f == 2 ? "R5" : "R6");
        accs = 0; outs = 0; prev_stall = 0; prev_out = 0;
        @(negedge clk);
        start = 1; depth_code = 4'(depth); pal_fmt = 2'(f); mono = m;
        @(negedge clk);
        start = 0;
        exp_done = (total == 0);
        if (total == 0) begin
            in_valid = 1; #1;
            chk(in_ready == 0, "R2 no intake", longint'(in_ready), 0);
        end
        for (int cyc = 0; cyc < 3000; cyc++) begin
            chk(done == exp_done, "R11 done timing", longint'(done), longint'(exp_done));
            if (exp_done) break;
            if (scramble) begin
                pal_fmt = 2'($urandom); mono = 1'($urandom);
                start = (cyc == 3); depth_code = (cyc == 3) ? 4'd1 : depth_code;
            end
            in_valid = (($urandom % 4) >= stall);
            in_word = $urandom;
            out_ready = (($urandom % 4) >= stall);
            #1;
            if (prev_stall)
                chk(out_valid && {out_transp, out_rgb} == prev_out, "R10 hold",
                    longint'({out_transp, out_rgb}), prev_out);
            if (out_valid && out_ready) begin
                longint e;
                e = (q.size() > 0) ? q.pop_front() : -1;
                chk({out_transp, out_rgb} == e, {tag, " R8 R12 value"},
                    longint'({out_transp, out_rgb}), e);
                outs++;
                exp_done = (outs == total);
            end
            if (in_valid && in_ready) begin
                if (accs >= total) chk(0, "R1 extra intake", accs + 1, total);
                q.push_back(ref_conv(in_word, f, m));
                accs++;
            end
            prev_stall = out_valid && !out_ready;
            prev_out = {out_transp, out_rgb};
            @(negedge clk);
            start = 0;
        end
        chk(accs == total, "R1 count", accs, total);
        in_valid = 0; out_ready = 0; pal_fmt = 2'(f); mono = m;
        if (total != 0) begin used_fmt = f; used_ok = 1; end
        #1;
        chk(fmt_stale == (!used_ok || used_fmt != f), "R9 stale after run",
            longint'(fmt_stale), longint'(!used_ok || used_fmt != f));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(out_valid == 0 && done == 0 && in_ready == 0, "R11 reset outputs",
            longint'({out_valid, done, in_ready}), 0);
        chk(fmt_stale == 1, "R9 stale at reset", longint'(fmt_stale), 1);
        run(0, 1, 0, 0, 0);                      // R2 code 0
        chk(fmt_stale == 1, "R2 R9 unsupported keeps stale", longint'(fmt_stale), 1);
        run(1, 0, 0, 0, 0);                      // R3 full throughput, 4 entries
        run(2, 1, 0, 0, 1);                      // R4, 16 entries
        run(2, 2, 0, 0, 2);                      // R5 stalls
        run(3, 3, 0, 0, 1);                      // R6, 256 entries
        run(2, 1, 1, 0, 1);                      // R7 mono
        run(2, 3, 1, 0, 0);                      // R7 mono layout 3
        run(3, 2, 0, 1, 2);                      // R12 scrambled config, R11 stray start
        run(5, 0, 0, 0, 0);                      // R2 code 5
        pal_fmt = 2'd0; #1;
        chk(fmt_stale == 1, "R9 changed layout", longint'(fmt_stale), 1);
        pal_fmt = 2'd2; #1;
        chk(fmt_stale == 0, "R9 matching layout", longint'(fmt_stale), 0);
        run(1, 0, 0, 0, 3);                      // heavy back-pressure
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule